// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Flag Nibble

This block is the arithmetic and logic datapath of a small accumulator machine. In the same combinational pass it forms an 8-bit result and a new set of four status flags: zero, subtract, half-carry and carry. It handles ten operations. These are add, add with carry-in, subtract, subtract with borrow-in, compare, increment, decrement and the three bitwise operations AND, OR and XOR.

The caller supplies the operation code and the accumulator byte. It also supplies a second operand, a carry-in bit and the current flag nibble. The block returns the result byte, a write-enable that says whether the accumulator should take that byte, and the updated flags. Every operation has its own policy for each flag: computed, forced or carried through. Half-carry comes from the nibble boundary, so the flag output is more than a by-product of the sum. There is no state and no clock in the block.

Top module: `alu8_core`

## Requirements
- R1: `flags_o` packs carry in bit 0, half-carry in bit 1, subtract in bit 2 and zero in bit 3; bits 7 to 4 are always zero. `flags_i` uses the same layout for its four bits.
- R2: Code 0 (add) gives a+b and code 1 (add with carry) gives a+b+cin. Both clear the subtract flag, set carry on a carry out of bit 7, and set half-carry to bit 4 of (a xor b xor result).
- R3: Code 2 (subtract) gives a-b and code 3 (subtract with borrow) gives a-b-cin. Both set the subtract flag, set carry on a borrow out of bit 7, and set half-carry to bit 4 of (a xor b xor result).
- R4: Code 4 (compare) drives the difference a-b on `res_o` and sets all four flags exactly as code 2 would, but holds `res_we_o` low.
- R5: Code 5 (increment a) and code 6 (decrement a) ignore b and cin and pass the carry flag from `flags_i` through unchanged. Increment sets half-carry when the result's low nibble is 0x0 and clears subtract. Decrement sets half-carry when the result's low nibble is 0xF and sets subtract.
- R6: Code 7 (AND), code 8 (OR) and code 9 (XOR) clear carry and subtract. AND sets half-carry; OR and XOR clear it.
- R7: Codes 10 to 15 are reserved: `res_o` equals a, `res_we_o` is low, and the low flag nibble equals `flags_i`.
- R8: For codes 0 to 9, the zero flag is set exactly when the 8-bit truncated result is zero, including results that wrapped.
- R9: `res_we_o` is high for codes 0 to 3 and 5 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (see R2 to R7) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry or borrow input for codes 1 and 3 |
| flags_i | input | 4 | Current flags, same layout as flags_o |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Accumulator write-enable |
| flags_o | output | 8 | Updated flags, upper four bits zero |

## Verification
The two functions that can fall in the same evaluation are the carry-in ripple and the nibble half-carry. A single carry-in bit can raise half-carry, carry and zero all at once. The bench provokes this with add-with-carry of 0xFF and 0x00 plus an incoming 1, and with subtract-with-borrow of 0x10 minus 0x0F minus 1. In each case it judges all three flags against values worked out by hand. A full sweep of increment and decrement over all 256 accumulator values also checks that the half-carry and zero rules hold while carry stays untouched.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W   = 8;
    localparam int NIB_BIT = 4;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_AND = 4'd7,
        OP_OR  = 4'd8,
        OP_XOR = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } alu_flags_t;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    function automatic logic nib_carry(input logic [ALU_W-1:0] x,
                                       input logic [ALU_W-1:0] y,
                                       input logic [ALU_W-1:0] r);
        logic [ALU_W-1:0] t;
        t = x ^ y ^ r;
        return t[NIB_BIT];
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         h_o
);
    localparam int FW = W + 1;

    logic [FW-1:0] full;
    logic [FW-1:0] ext_a;
    logic [FW-1:0] ext_b;
    logic [FW-1:0] ext_c;

    always_comb begin
        ext_a = {1'b0, a_i};
        ext_b = {1'b0, b_i};
        ext_c = {{W{1'b0}}, cin_i};
        if (sub_i) full = ext_a - ext_b - ext_c;
        else       full = ext_a + ext_b + ext_c;
        res_o = full[W-1:0];
        c_o   = full[W];
        h_o   = nib_carry(a_i, b_i, full[W-1:0]);
    end

    always_comb begin
        if (sub_i)
            AST_SUB_BORROW: assert (c_o == (ext_a < (ext_b + ext_c)))
                else $error("borrow mismatch"); // R3
        else
            AST_ADD_CARRY: assert (c_o == ((ext_a + ext_b + ext_c) > {1'b0, {W{1'b1}}}))
                else $error("carry mismatch"); // R2
    end

endmodule

// File: rtl/alu8_incdec.sv
module alu8_incdec
    import alu8_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] a_i,
    input  logic         dec_i,
    output logic [W-1:0] res_o,
    output logic         h_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (dec_i) begin
            res_o = a_i - ONE;
            h_o   = (res_o[NIB_BIT-1:0] == {NIB_BIT{1'b1}});
        end else begin
            res_o = a_i + ONE;
            h_o   = (res_o[NIB_BIT-1:0] == {NIB_BIT{1'b0}});
        end
    end

    always_comb begin
        if (dec_i)
            AST_DEC_HALF: assert (h_o == (a_i[NIB_BIT-1:0] == {NIB_BIT{1'b0}}))
                else $error("dec half-carry"); // R5
        else
            AST_INC_HALF: assert (h_o == (a_i[NIB_BIT-1:0] == {NIB_BIT{1'b1}}))
                else $error("inc half-carry"); // R5
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i & b_i;
        endcase
    end

    always_comb begin
        if (sel_i == LG_AND)
            AST_AND_SUBSET: assert ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0)
                else $error("and leaks bits"); // R6
        if (sel_i == LG_OR)
            AST_OR_SUPERSET: assert ((a_i & ~res_o) == '0 && (b_i & ~res_o) == '0)
                else $error("or drops bits"); // R6
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = ALU_W
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [3:0]   flags_i,
    output logic [W-1:0] res_o,
    output logic         res_we_o,
    output logic [7:0]   flags_o
);
    alu_flags_t   fin;
    alu_flags_t   fnext;
    logic [W-1:0] as_res;
    logic         as_c;
    logic         as_h;
    logic         as_sub;
    logic         as_cin;
    logic [W-1:0] id_res;
    logic         id_h;
    logic         id_dec;
    logic [W-1:0] lg_res;
    logic_sel_e   lg_sel;

    assign fin    = alu_flags_t'(flags_i);
    assign as_sub = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP);
    assign as_cin = cin_i & ((op_i == OP_ADC) || (op_i == OP_SBC));
    assign id_dec = (op_i == OP_DEC);

    always_comb begin
        if (op_i == OP_OR)       lg_sel = LG_OR;
        else if (op_i == OP_XOR) lg_sel = LG_XOR;
        else                     lg_sel = LG_AND;
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .c_o   (as_c),
        .h_o   (as_h)
    );

    alu8_incdec #(.W(W)) u_incdec (
        .a_i   (a_i),
        .dec_i (id_dec),
        .res_o (id_res),
        .h_o   (id_h)
    );

    alu8_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (lg_sel),
        .res_o (lg_res)
    );

    always_comb begin
        res_o    = a_i;
        res_we_o = 1'b0;
        fnext    = fin;
        unique case (op_i)
            OP_ADD, OP_ADC: begin
                res_o    = as_res;
                res_we_o = 1'b1;
                fnext    = '{z: (as_res == '0), n: 1'b0, h: as_h, c: as_c};
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                res_o    = as_res;
                res_we_o = (op_i != OP_CMP);
                fnext    = '{z: (as_res == '0), n: 1'b1, h: as_h, c: as_c};
            end
            OP_INC, OP_DEC: begin
                res_o    = id_res;
                res_we_o = 1'b1;
                fnext    = '{z: (id_res == '0), n: id_dec, h: id_h, c: fin.c};
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_o    = lg_res;
                res_we_o = 1'b1;
                fnext    = '{z: (lg_res == '0), n: 1'b0, h: (op_i == OP_AND), c: 1'b0};
            end
            default: begin
                res_o    = a_i;
                res_we_o = 1'b0;
                fnext    = fin;
            end
        endcase
        flags_o = {4'b0000, fnext};
    end

    always_comb begin
        if (op_i == OP_CMP)
            AST_CMP_NO_WRITE: assert (!res_we_o && flags_o[2])
                else $error("compare wrote result"); // R4
        if (op_i == OP_INC || op_i == OP_DEC)
            AST_INCDEC_KEEP_C: assert (flags_o[0] == flags_i[0])
                else $error("inc/dec touched carry"); // R5
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
            AST_LOGIC_NC_CLEAR: assert (!flags_o[0] && !flags_o[2])
                else $error("logic op left N or C"); // R6
        if (op_i <= 4'd9)
            AST_ZERO_TRACKS: assert (flags_o[3] == (res_o == '0))
                else $error("zero flag mismatch"); // R8
        if (op_i > 4'd9)
            AST_RESERVED_IDLE: assert (!res_we_o && flags_o[3:0] == flags_i && res_o == a_i)
                else $error("reserved code acted"); // R7
        if (op_i == OP_ADD || op_i == OP_ADC)
            AST_ADD_N_CLEAR: assert (!flags_o[2])
                else $error("add set N"); // R2
    end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i;
    logic [7:0] a_i;
    logic [7:0] b_i;
    logic       cin_i;
    logic [3:0] flags_i;
    logic [7:0] res_o;
    logic       res_we_o;
    logic [7:0] flags_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut (
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .cin_i    (cin_i),
        .flags_i  (flags_i),
        .res_o    (res_o),
        .res_we_o (res_we_o),
        .flags_o  (flags_o)
    );

    // vector: op, a, b, cin, flags_in, exp_res, exp_we, exp_flags (Z N H C = 8 4 2 1)
    localparam int NV = 26;
    localparam logic [37:0] VEC [NV] = '{
        {4'd0,  8'h12, 8'h34, 1'b1, 4'hF, 8'h46, 1'b1, 4'h0}, // R2 plain add, cin ignored
        {4'd0,  8'h0F, 8'h01, 1'b0, 4'h0, 8'h10, 1'b1, 4'h2}, // R2 half carry
        {4'd0,  8'hF0, 8'h10, 1'b0, 4'h0, 8'h00, 1'b1, 4'h9}, // R2 R8 wrap to zero
        {4'd1,  8'h0F, 8'h00, 1'b1, 4'h0, 8'h10, 1'b1, 4'h2}, // R2 cin into nibble
        {4'd1,  8'hFF, 8'h00, 1'b1, 4'h0, 8'h00, 1'b1, 4'hB}, // R2 R8 Z H C at once
        {4'd2,  8'h10, 8'h01, 1'b0, 4'h0, 8'h0F, 1'b1, 4'h6}, // R3 nibble borrow
        {4'd2,  8'h05, 8'h05, 1'b1, 4'h0, 8'h00, 1'b1, 4'hC}, // R3 equal
        {4'd2,  8'h00, 8'h01, 1'b0, 4'h0, 8'hFF, 1'b1, 4'h7}, // R3 full borrow
        {4'd3,  8'h10, 8'h0F, 1'b1, 4'h0, 8'h00, 1'b1, 4'hE}, // R3 borrow-in to zero
        {4'd3,  8'h00, 8'h00, 1'b1, 4'h0, 8'hFF, 1'b1, 4'h7}, // R3 borrow-in only
        {4'd4,  8'h3C, 8'h2F, 1'b1, 4'h0, 8'h0D, 1'b0, 4'h6}, // R4 compare
        {4'd4,  8'h40, 8'h40, 1'b0, 4'h1, 8'h00, 1'b0, 4'hC}, // R4 compare equal
        {4'd5,  8'hFF, 8'h77, 1'b0, 4'h1, 8'h00, 1'b1, 4'hB}, // R5 inc wrap keeps C
        {4'd5,  8'h41, 8'h00, 1'b1, 4'h0, 8'h42, 1'b1, 4'h0}, // R5 inc plain
        {4'd5,  8'h0F, 8'h00, 1'b0, 4'hE, 8'h10, 1'b1, 4'h2}, // R5 inc nibble
        {4'd6,  8'h01, 8'h00, 1'b0, 4'h0, 8'h00, 1'b1, 4'hC}, // R5 dec to zero
        {4'd6,  8'h00, 8'h00, 1'b0, 4'h1, 8'hFF, 1'b1, 4'h7}, // R5 dec wrap keeps C
        {4'd6,  8'h10, 8'h00, 1'b0, 4'h0, 8'h0F, 1'b1, 4'h6}, // R5 dec nibble
        {4'd7,  8'hF0, 8'h0F, 1'b1, 4'hF, 8'h00, 1'b1, 4'hA}, // R6 and zero
        {4'd7,  8'h3C, 8'h0F, 1'b0, 4'h0, 8'h0C, 1'b1, 4'h2}, // R6 and
        {4'd8,  8'h00, 8'h00, 1'b0, 4'hF, 8'h00, 1'b1, 4'h8}, // R6 or zero
        {4'd8,  8'h50, 8'h05, 1'b0, 4'hF, 8'h55, 1'b1, 4'h0}, // R6 or
        {4'd9,  8'hAA, 8'hAA, 1'b0, 4'h7, 8'h00, 1'b1, 4'h8}, // R6 xor zero
        {4'd9,  8'hA5, 8'h0F, 1'b1, 4'h0, 8'hAA, 1'b1, 4'h0}, // R6 xor
        {4'd10, 8'h77, 8'h11, 1'b1, 4'h5, 8'h77, 1'b0, 4'h5}, // R7 reserved
        {4'd15, 8'h00, 8'hFF, 1'b1, 4'hA, 8'h00, 1'b0, 4'hA}  // R7 reserved
    };

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd1)      return "R2";
        else if (op <= 4'd3) return "R3";
        else if (op == 4'd4) return "R4";
        else if (op <= 4'd6) return "R5";
        else if (op <= 4'd9) return "R6";
        else                 return "R7";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic [3:0] f);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; cin_i = c; flags_i = f;
        #2;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        op_i = 4'd0; a_i = 8'h00; b_i = 8'h00; cin_i = 1'b0; flags_i = 4'h0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset-time state: add of zeros gives zero result with only Z set
        apply(4'd0, 8'h00, 8'h00, 1'b0, 4'h0);
        check("R8", "reset res", res_o, 8'h00);
        check("R1", "reset flags", flags_o, 8'h08);
        check("R9", "reset we", {7'd0, res_we_o}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            apply(v[37:34], v[33:26], v[25:18], v[17], v[16:13]);
            check(tag_of(v[37:34]), "res", res_o, v[12:5]);
            check((v[37:34] == 4'd4 || v[37:34] > 4'd9) ? tag_of(v[37:34]) : "R9",
                  "we", {7'd0, res_we_o}, {7'd0, v[4]});
            check(tag_of(v[37:34]), "flags", {4'd0, flags_o[3:0]}, {4'd0, v[3:0]});
            check("R1", "upper flag bits", {4'd0, flags_o[7:4]}, 8'h00);
        end

        // R5 sweep: increment and decrement over every accumulator value, C carried through
        for (int a = 0; a < 256; a++) begin
            logic [7:0] er;
            logic [3:0] ef;
            logic cin_bit;
            cin_bit = a[0];
            apply(4'd5, 8'(a), 8'hC3, 1'b1, {3'b010, cin_bit});
            er = 8'(a + 1);
            ef = {(er == 8'h00), 1'b0, (er[3:0] == 4'h0), cin_bit};
            check("R5", "inc sweep res", res_o, er);
            check("R5", "inc sweep flags", flags_o, {4'd0, ef});
            apply(4'd6, 8'(a), 8'h3C, 1'b0, {3'b001, cin_bit});
            er = 8'(a - 1);
            ef = {(er == 8'h00), 1'b1, (er[3:0] == 4'hF), cin_bit};
            check("R5", "dec sweep res", res_o, er);
            check("R5", "dec sweep flags", flags_o, {4'd0, ef});
        end

        // R4 compare matches subtract flags across a set of operand pairs
        for (int k = 0; k < 16; k++) begin
            logic [7:0] sf;
            logic [7:0] sr;
            apply(4'd2, 8'(k * 17), 8'(k * 29 + 3), 1'b0, 4'h0);
            sf = flags_o;
            sr = res_o;
            apply(4'd4, 8'(k * 17), 8'(k * 29 + 3), 1'b0, 4'h0);
            check("R4", "cmp flags vs sub", flags_o, sf);
            check("R4", "cmp diff vs sub", res_o, sr);
            check("R4", "cmp we", {7'd0, res_we_o}, 8'h00);
        end

        // R8 wrapped add: 0x80 + 0x80 truncates to zero
        apply(4'd0, 8'h80, 8'h80, 1'b0, 4'h0);
        check("R8", "wrap add flags", flags_o, 8'h09);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule